// File: doc/BRIEF.md
# Delayed Pulse Train Generator

This block drives one output pulse line for a timing card. It has two ways to start. In delay mode it waits for a clean edge on a synchronised trigger input, counts a programmed number of 4 ns ticks, and then emits its pulses. In generator mode it ignores the trigger and starts when a free-running time-of-day counter (whole seconds plus ticks within the second) reaches a programmed absolute start time. In both modes the output is either a single pulse or a train of pulses. Width, spacing and pulse count are programmable, and a continuous setting repeats the train without end.

The trigger qualifier rejects short glitches. A trigger that arrives while a delay or train is already running is dropped and recorded in a sticky flag. Dropping the enable input aborts any activity at once. It also forces the line low and clears the flag. A board with four outputs uses four instances, each with its own settings.

Top module: `pulse_train_gen`

## Requirements
- R1: During and directly after reset, `pulse_out`, `busy` and `missed` are all 0.
- R2: A trigger counts only when `trig_in` is sampled high on MIN_HIGH (default 6) consecutive rising clock edges. A shorter high pulse produces no output and leaves `busy` at 0.
- R3: In delay mode (`mode_gen`=0), let `trig_in` be first sampled high at edge n of a qualifying pulse. Then `pulse_out` goes high just after edge n+MIN_HIGH+`delay_ticks` (`delay_ticks` >= 1).
- R4: Each pulse stays high for exactly `width_ticks` clock cycles. Consecutive pulses of a train are separated by exactly `space_ticks` low cycles. Both values must be at least 1.
- R5: `repeat_m1` holds the pulse count minus one. The value 0 gives one pulse and the value k gives k+1 pulses, after which `busy` returns to 0.
- R6: With `continuous`=1, `repeat_m1` is ignored and pulses repeat at the width/spacing period until `enable` goes low.
- R7: In generator mode (`mode_gen`=1), the first pulse rises just after the second rising edge at which {`tod_sec`,`tod_tick`} >= {`start_sec`,`start_tick`}. The comparison uses seconds first, then ticks. Triggers are ignored in this mode. After one train, nothing more is emitted until `enable` is dropped and raised again.
- R8: In delay mode, a qualified trigger that arrives while `busy`=1 starts nothing and sets `missed` to 1. `missed` stays 1 until `enable` is low at a clock edge, which clears it.
- R9: When `enable` is sampled low, `pulse_out` and `busy` are 0 after that edge, whatever state the block was in.
- R10: In delay mode, once a train completes, the block accepts the next qualified trigger without any other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (one period per 4 ns tick) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low aborts and clears the missed flag |
| mode_gen | input | 1 | 0: start after trigger plus delay; 1: start at absolute time |
| continuous | input | 1 | 1: repeat pulses until disabled |
| trig_in | input | 1 | Synchronised trigger level |
| tod_sec | input | SEC_W (32) | Time-of-day whole seconds |
| tod_tick | input | TICK_W (28) | Time-of-day ticks within the second |
| start_sec | input | SEC_W (32) | Absolute start time, seconds |
| start_tick | input | TICK_W (28) | Absolute start time, ticks |
| delay_ticks | input | DLY_W (35) | Trigger-to-output delay in ticks |
| width_ticks | input | TICK_W (28) | Pulse high time in ticks |
| space_ticks | input | TICK_W (28) | Low time between pulses in ticks |
| repeat_m1 | input | CNT_W (16) | Pulse count minus one |
| pulse_out | output | 1 | Pulse output line |
| busy | output | 1 | A delay or train is in progress |
| missed | output | 1 | Sticky: a trigger was dropped while busy |

## Verification
The bench sends a five-cycle glitch and then a six-cycle trigger. A qualifier whose threshold is off by one would fire on the glitch or add a cycle of delay, and the scoreboard would see an unexpected pulse or a shifted rise time. Trains with a count field of 0 and of 3 expose a count that is not stored minus one: that design emits one pulse too many or too few. A continuous run is stopped in the middle of a low gap, and a run is aborted both during the delay and during a high phase. A design that finishes the current phase, or that rises once more after the disable, fails these checks. In generator mode the start tick is set below the current tick while the start second lies in the future. A comparator that checks ticks alone would start at once. A design that leaves the train in a re-armed state would fire again after the first train.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ARMED = 3'd1,
        S_DELAY = 3'd2,
        S_HIGH  = 3'd3,
        S_LOW   = 3'd4
    } ptg_state_e;

endpackage

// File: rtl/ptg_trig_qual.sv
module ptg_trig_qual #(
    parameter int MIN_HIGH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic fire_o
);
    localparam int RW = $clog2(MIN_HIGH + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          fire;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d = qual_q;
        qual_d.fire = 1'b0;
        if (!trig_in) begin
            qual_d.run = '0;
        end else begin
            if (qual_q.run == RW'(MIN_HIGH - 1)) begin
                qual_d.fire = 1'b1;
            end
            if (qual_q.run != RW'(MIN_HIGH)) begin
                qual_d.run = qual_q.run + RW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_q <= '0;
        end else begin
            qual_q <= qual_d;
        end
    end

    assign fire_o = qual_q.fire;

    // One accepted edge yields exactly one fire cycle, even while the input stays high (R2)
    assert_single_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // A fire cycle needs the input high on the edge that produced it (R2)
    assert_fire_needs_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire_o) |-> $past(trig_in));

endmodule

// File: rtl/ptg_time_match.sv
module ptg_time_match #(
    parameter int SEC_W  = 32,
    parameter int TICK_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  tod_sec,
    input  logic [TICK_W-1:0] tod_tick,
    input  logic [SEC_W-1:0]  start_sec,
    input  logic [TICK_W-1:0] start_tick,
    output logic              reached_o
);
    localparam int TW = SEC_W + TICK_W;

    logic reached_d, reached_q;
    logic [TW-1:0] now_w, start_w;

    always_comb begin
        now_w     = {tod_sec, tod_tick};
        start_w   = {start_sec, start_tick};
        reached_d = (now_w >= start_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reached_q <= 1'b0;
        end else begin
            reached_q <= reached_d;
        end
    end

    assign reached_o = reached_q;

    // A later second always wins over the tick field (R7)
    assert_sec_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_sec < start_sec) |=> !reached_o);

endmodule

// File: rtl/ptg_seq.sv
module ptg_seq
    import ptg_pkg::*;
#(
    parameter int DLY_W  = 35,
    parameter int TICK_W = 28,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode_gen,
    input  logic              continuous,
    input  logic              fire,
    input  logic              reached,
    input  logic [DLY_W-1:0]  delay_ticks,
    input  logic [TICK_W-1:0] width_ticks,
    input  logic [TICK_W-1:0] space_ticks,
    input  logic [CNT_W-1:0]  repeat_m1,
    output logic              pulse_o,
    output logic              busy_o,
    output logic              missed_o
);
    localparam int CW = (DLY_W > TICK_W) ? DLY_W : TICK_W;

    typedef struct packed {
        ptg_state_e       state;
        logic [CW-1:0]    cnt;
        logic [CNT_W-1:0] rem;
        logic             missed;
        logic             spent;
    } seq_t;

    seq_t seq_d, seq_q;
    logic active_q;

    always_comb begin
        active_q = (seq_q.state == S_DELAY) || (seq_q.state == S_HIGH) ||
                   (seq_q.state == S_LOW);
    end

    always_comb begin
        seq_d = seq_q;
        if (!enable) begin
            seq_d.state  = S_IDLE;
            seq_d.cnt    = '0;
            seq_d.rem    = '0;
            seq_d.missed = 1'b0;
            seq_d.spent  = 1'b0;
        end else begin
            if (fire && !mode_gen && active_q) begin
                seq_d.missed = 1'b1;
            end
            unique case (seq_q.state)
                S_IDLE: begin
                    if (!seq_q.spent) begin
                        seq_d.state = S_ARMED;
                    end
                end
                S_ARMED: begin
                    if (mode_gen) begin
                        if (reached) begin
                            seq_d.state = S_HIGH;
                            seq_d.cnt   = CW'(width_ticks) - CW'(1);
                            seq_d.rem   = repeat_m1;
                        end
                    end else if (fire) begin
                        seq_d.state = S_DELAY;
                        seq_d.cnt   = CW'(delay_ticks) - CW'(1);
                    end
                end
                S_DELAY: begin
                    if (seq_q.cnt == '0) begin
                        seq_d.state = S_HIGH;
                        seq_d.cnt   = CW'(width_ticks) - CW'(1);
                        seq_d.rem   = repeat_m1;
                    end else begin
                        seq_d.cnt = seq_q.cnt - CW'(1);
                    end
                end
                S_HIGH: begin
                    if (seq_q.cnt != '0) begin
                        seq_d.cnt = seq_q.cnt - CW'(1);
                    end else if (!continuous && (seq_q.rem == '0)) begin
                        if (mode_gen) begin
                            seq_d.state = S_IDLE;
                            seq_d.spent = 1'b1;
                        end else begin
                            seq_d.state = S_ARMED;
                        end
                    end else begin
                        seq_d.state = S_LOW;
                        seq_d.cnt   = CW'(space_ticks) - CW'(1);
                        if (!continuous) begin
                            seq_d.rem = seq_q.rem - CNT_W'(1);
                        end
                    end
                end
                S_LOW: begin
                    if (seq_q.cnt == '0) begin
                        seq_d.state = S_HIGH;
                        seq_d.cnt   = CW'(width_ticks) - CW'(1);
                    end else begin
                        seq_d.cnt = seq_q.cnt - CW'(1);
                    end
                end
                default: begin
                    seq_d.state = S_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: S_IDLE, cnt: '0, rem: '0, missed: 1'b0, spent: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pulse_o  = (seq_q.state == S_HIGH);
    assign busy_o   = active_q;
    assign missed_o = seq_q.missed;

    // Disable forces the line and busy low on the next edge (R9)
    assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pulse_o && !busy_o));

    // The missed flag only clears through disable (R8)
    assert_missed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && missed_o) |=> missed_o);

    // Delay counter steps down by one per tick (R3)
    assert_delay_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && seq_q.state == S_DELAY && seq_q.cnt != '0) |=>
        (seq_q.state == S_DELAY && seq_q.cnt == $past(seq_q.cnt) - CW'(1)));

    // A high phase is not cut short while its counter is nonzero (R4)
    assert_high_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && seq_q.state == S_HIGH && seq_q.cnt != '0) |=> pulse_o);

    // The last pulse of a finite train ends the train (R5)
    assert_last_pulse_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !continuous && seq_q.state == S_HIGH && seq_q.cnt == '0 &&
         seq_q.rem == '0) |=> (!pulse_o && !busy_o));

    // Continuous mode always goes on to a gap after a pulse (R6)
    assert_continuous_goes_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && continuous && seq_q.state == S_HIGH && seq_q.cnt == '0) |=>
        (seq_q.state == S_LOW));

    // Waiting for the start time, triggers change nothing (R7)
    assert_gen_ignores_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode_gen && seq_q.state == S_ARMED && !reached) |=>
        (seq_q.state == S_ARMED));

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
    parameter int MIN_HIGH = 6,
    parameter int SEC_W    = 32,
    parameter int TICK_W   = 28,
    parameter int DLY_W    = 35,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mode_gen,
    input  logic              continuous,
    input  logic              trig_in,
    input  logic [SEC_W-1:0]  tod_sec,
    input  logic [TICK_W-1:0] tod_tick,
    input  logic [SEC_W-1:0]  start_sec,
    input  logic [TICK_W-1:0] start_tick,
    input  logic [DLY_W-1:0]  delay_ticks,
    input  logic [TICK_W-1:0] width_ticks,
    input  logic [TICK_W-1:0] space_ticks,
    input  logic [CNT_W-1:0]  repeat_m1,
    output logic              pulse_out,
    output logic              busy,
    output logic              missed
);
    logic fire_w;
    logic reached_w;

    ptg_trig_qual #(
        .MIN_HIGH (MIN_HIGH)
    ) qual_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .fire_o  (fire_w)
    );

    ptg_time_match #(
        .SEC_W  (SEC_W),
        .TICK_W (TICK_W)
    ) match_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tod_sec    (tod_sec),
        .tod_tick   (tod_tick),
        .start_sec  (start_sec),
        .start_tick (start_tick),
        .reached_o  (reached_w)
    );

    ptg_seq #(
        .DLY_W  (DLY_W),
        .TICK_W (TICK_W),
        .CNT_W  (CNT_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .mode_gen    (mode_gen),
        .continuous  (continuous),
        .fire        (fire_w),
        .reached     (reached_w),
        .delay_ticks (delay_ticks),
        .width_ticks (width_ticks),
        .space_ticks (space_ticks),
        .repeat_m1   (repeat_m1),
        .pulse_o     (pulse_out),
        .busy_o      (busy),
        .missed_o    (missed)
    );

endmodule

// File: tb/pulse_train_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_train_gen_tb_top;

    localparam int TPS = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        mode_gen = 1'b0;
    logic        continuous = 1'b0;
    logic        trig_in = 1'b0;
    logic [31:0] tod_sec;
    logic [27:0] tod_tick;
    logic [31:0] start_sec = '0;
    logic [27:0] start_tick = '0;
    logic [34:0] delay_ticks = '0;
    logic [27:0] width_ticks = '0;
    logic [27:0] space_ticks = '0;
    logic [15:0] repeat_m1 = '0;
    logic        pulse_out, busy, missed;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int seen = 0;
    bit done = 1'b0;

    int    exp_rise[$];
    int    exp_width[$];
    string exp_tag[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign tod_sec  = 32'(cyc / TPS);
    assign tod_tick = 28'(cyc % TPS);

    pulse_train_gen dut_i (
        .clk (clk), .rst_n (rst_n), .enable (enable), .mode_gen (mode_gen),
        .continuous (continuous), .trig_in (trig_in),
        .tod_sec (tod_sec), .tod_tick (tod_tick),
        .start_sec (start_sec), .start_tick (start_tick),
        .delay_ticks (delay_ticks), .width_ticks (width_ticks),
        .space_ticks (space_ticks), .repeat_m1 (repeat_m1),
        .pulse_out (pulse_out), .busy (busy), .missed (missed)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_train(input int r0, input int w, input int p, input int n,
                              input string tag);
        for (int i = 0; i < n; i++) begin
            exp_rise.push_back(r0 + i * (w + p));
            exp_width.push_back(w);
            exp_tag.push_back(tag);
        end
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic fire_trig(input int len, output int m);
        @(negedge clk);
        m = cyc;
        trig_in = 1'b1;
        repeat (len) @(negedge clk);
        trig_in = 1'b0;
    endtask

    // Monitor: measure each pulse and compare against the scoreboard
    int  cur_rise = 0;
    int  cur_len = 0;
    bit  prev_out = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse_out && !prev_out) begin
                cur_rise = cyc;
                cur_len  = 1;
            end else if (pulse_out) begin
                cur_len++;
            end else if (prev_out) begin
                seen++;
                if (exp_rise.size() == 0) begin
                    chk(1'b0, "R8", "unexpected pulse rise cycle", cur_rise, -1);
                end else begin
                    automatic int    er = exp_rise.pop_front();
                    automatic int    ew = exp_width.pop_front();
                    automatic string et = exp_tag.pop_front();
                    chk(cur_rise == er, et, "pulse rise cycle", cur_rise, er);
                    chk(cur_len == ew, et, "pulse width", cur_len, ew);
                end
            end
            prev_out = pulse_out;
        end
    end

    initial begin
        int m, m2, r0, s0, c, ss, st;
        repeat (4) @(negedge clk);
        chk(!pulse_out && !busy && !missed, "R1", "outputs in reset",
            {pulse_out, busy, missed}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pulse_out && !busy && !missed, "R1", "outputs after reset",
            {pulse_out, busy, missed}, 0);

        // Delay mode, single pulse setup
        delay_ticks = 35'd20; width_ticks = 28'd4; space_ticks = 28'd3;
        repeat_m1 = 16'd0; mode_gen = 1'b0; continuous = 1'b0;
        enable = 1'b1;
        repeat (3) @(negedge clk);

        // R2: five-cycle glitch must be rejected
        s0 = seen;
        fire_trig(5, m);
        repeat (60) @(negedge clk);
        chk(seen == s0, "R2", "pulses after glitch", seen - s0, 0);
        chk(!busy, "R2", "busy after glitch", busy, 0);

        // R3/R5: minimum qualifying trigger, count field 0 gives one pulse
        fire_trig(6, m);
        push_train(m + 7 + 20, 4, 3, 1, "R3");
        wait_cyc(m + 27 + 15);
        chk(seen == s0 + 1, "R5", "pulse count for field 0", seen - s0, 1);
        chk(!busy, "R5", "busy after single pulse", busy, 0);

        // R4/R5/R8: four-pulse train, a second trigger lands inside it
        delay_ticks = 35'd10; width_ticks = 28'd5; space_ticks = 28'd4;
        repeat_m1 = 16'd3;
        s0 = seen;
        fire_trig(6, m);
        push_train(m + 17, 5, 4, 4, "R4");
        wait_cyc(m + 20);
        fire_trig(7, m2);
        wait_cyc(m + 60);
        chk(missed, "R8", "missed after trigger during train", missed, 1);
        chk(seen == s0 + 4, "R5", "pulse count for field 3", seen - s0, 4);
        chk(!busy, "R5", "busy after train", busy, 0);

        // R10: re-armed without action; R8 flag stays set
        width_ticks = 28'd2; repeat_m1 = 16'd0;
        fire_trig(6, m);
        push_train(m + 17, 2, 4, 1, "R10");
        wait_cyc(m + 30);
        chk(missed, "R8", "missed still sticky", missed, 1);

        // R8: disable clears the flag
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk(!missed, "R8", "missed after disable", missed, 0);
        repeat (2) @(negedge clk);

        // R9: abort during delay
        delay_ticks = 35'd100; width_ticks = 28'd4;
        s0 = seen;
        fire_trig(6, m);
        wait_cyc(m + 40);
        enable = 1'b0;
        @(negedge clk);
        chk(!busy, "R9", "busy after abort in delay", busy, 0);
        enable = 1'b1;
        wait_cyc(m + 160);
        chk(seen == s0, "R9", "pulses after aborted delay", seen - s0, 0);

        // R9: abort during a high phase truncates the pulse at once
        delay_ticks = 35'd5; width_ticks = 28'd20;
        fire_trig(6, m);
        r0 = m + 12;
        push_train(r0, 4, 0, 1, "R9");
        wait_cyc(r0 + 3);
        enable = 1'b0;
        @(negedge clk);
        chk(!pulse_out, "R9", "line after abort in high", pulse_out, 0);
        enable = 1'b1;
        repeat (10) @(negedge clk);

        // R6: continuous, stop in the gap after the sixth pulse
        delay_ticks = 35'd5; width_ticks = 28'd3; space_ticks = 28'd2;
        repeat_m1 = 16'd0; continuous = 1'b1;
        s0 = seen;
        fire_trig(6, m);
        r0 = m + 12;
        push_train(r0, 3, 2, 6, "R6");
        wait_cyc(r0 + 28);
        enable = 1'b0;
        @(negedge clk);
        chk(!busy, "R6", "busy after stopping continuous", busy, 0);
        continuous = 1'b0;
        enable = 1'b1;
        repeat (20) @(negedge clk);
        chk(seen == s0 + 6, "R6", "pulses in continuous run", seen - s0, 6);

        // R7: generator mode, future second with a tick below the current tick
        enable = 1'b0;
        while ((cyc % TPS) < 100) @(negedge clk);
        mode_gen = 1'b1; width_ticks = 28'd4; space_ticks = 28'd6;
        repeat_m1 = 16'd1;
        c  = cyc;
        ss = c / TPS + 1;
        st = 37;
        start_sec  = 32'(ss);
        start_tick = 28'(st);
        @(negedge clk);
        enable = 1'b1;
        s0 = seen;
        push_train(ss * TPS + st + 2, 4, 6, 2, "R7");
        repeat (20) @(negedge clk);
        chk(!busy, "R7", "busy before start time", busy, 0);
        fire_trig(8, m);
        repeat (20) @(negedge clk);
        chk(seen == s0, "R7", "pulses from trigger in generator mode", seen - s0, 0);
        wait_cyc(ss * TPS + st + 40);
        chk(!busy, "R7", "busy after generator train", busy, 0);
        chk(!missed, "R7", "missed in generator mode", missed, 0);
        repeat (30) @(negedge clk);
        chk(seen == s0 + 2, "R7", "pulses with no re-fire", seen - s0, 2);

        chk(exp_rise.size() == 0, "R4", "expected pulses left unseen",
            exp_rise.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1-chain timeout: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule